// File: doc/BRIEF.md
# Single-error-correcting, double-error-detecting codec for a 72-bit memory word

The block protects a 64-bit memory word with eight check bits. A purely combinational encode path turns write data into a 72-bit stored word. A decode path turns a word read back into corrected data, a 7-bit syndrome and a three-way status. The status says one of three things: the word was clean, a single inverted bit was repaired, or the damage cannot be repaired. The decode path has one register stage. Results appear on the cycle after the read word is presented, and a new word can be presented every cycle.

The code is a Hamming code with an extra whole-word parity bit, and every parity group uses odd parity. When a single bit is inverted, the failing Hamming checks, read as a binary number, give the position of that bit. The check bits are protected in the same way as the data bits. An elaboration option mixes the word address into the Hamming check bits on both paths. A word returned from the wrong address then shows up as a detected error and is not silently accepted.

Top module: `secded_codec`

## Requirements
- R1: The stored word puts the overall parity bit at position 0. Hamming check bit k sits at position 2^k, for k from 0 to 6. Data bit i sits at the i-th position, in ascending order, that is neither 0 nor a power of two, so data bit 0 is at position 3 and data bit 63 is at position 71. enc_code follows enc_data and enc_addr in the same cycle.
- R2: In the stored word, each Hamming group has an odd number of ones. Group k is every position whose index has bit k set, folded address parity included. The whole 72-bit word also has an odd number of ones.
- R3: A word taken unchanged from the encoder, and decoded with the same address, gives dec_ok=1, dec_syndrome=0 and the original data one cycle later.
- R4: If one data position p (3 to 71) is inverted, then dec_syndrome=p, dec_ce=1 and the original data comes out.
- R5: If one Hamming check position (1, 2, 4, ..., 64) is inverted, then dec_syndrome equals that position, dec_ce=1 and the data is unchanged.
- R6: If only the overall parity bit at position 0 is inverted, then dec_syndrome=0, dec_ce=1 and the data is unchanged.
- R7: If the overall parity passes and the syndrome is nonzero (for example, two inverted bits), then dec_ue=1. The syndrome is the XOR of the inverted positions, and the data bits are passed through as read, with no correction.
- R8: If the overall parity fails and the syndrome is 72 or more, then dec_ue=1 and the data is passed through uncorrected.
- R9: When ADDR_FOLD=1, address bit a flips Hamming check bit (a mod 7) on both paths. The overall bit is not folded. Decoding with a different address therefore adds the XOR of the two fold vectors to the syndrome. Addresses whose fold vectors match decode as clean.
- R10: While rst is high, the decode outputs are cleared to zero, with no status flag set. From the first decode after reset, exactly one of dec_ok, dec_ce and dec_ue is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the decode register |
| rst | input | 1 | Synchronous active-high reset of the decode outputs |
| enc_data | input | DATA_W (64) | Data to encode |
| enc_addr | input | ADDR_W (32) | Word address used for folding on the encode path |
| enc_code | output | 72 | Stored word, combinational |
| dec_code | input | 72 | Word read back from memory |
| dec_addr | input | ADDR_W (32) | Word address used for folding on the decode path |
| dec_data | output | DATA_W (64) | Corrected or passed-through data, registered |
| dec_syndrome | output | 7 | Failing Hamming checks read as a position, registered |
| dec_ok | output | 1 | The word was clean |
| dec_ce | output | 1 | A single inverted bit was corrected |
| dec_ue | output | 1 | The error cannot be corrected |

## Verification
The assertions check these properties on every cycle:
- The stored word has odd overall parity.
- An encoder output that is looped straight back decodes clean, with the same data one cycle later.
- The status is one-hot after reset and clear during reset.
- An uncorrectable result never shows a zero syndrome.
- A correction never claims a position beyond 71, and such a syndrome always raises the uncorrectable flag.

Only the bench scenarios can show the following:
- Every one of the 72 single-bit inversions, including check bits and the overall bit, lands on its exact syndrome and restores the data.
- Double and triple patterns are classified correctly.
- Folded addresses behave as described, including two address bits in the same slice that cancel.

// File: rtl/secded_pkg.sv
package secded_pkg;

   // Widest codeword the mask helpers can describe.
   localparam int MAX_CW = 256;

   typedef logic [MAX_CW-1:0] cw_mask_t;

   typedef enum logic [1:0] {
      DEC_OK = 2'd0,
      DEC_CE = 2'd1,
      DEC_UE = 2'd2
   } dec_status_e;

   // Hamming check count r: smallest r with 2^r >= data + r + 1.
   function automatic int ham_bits(input int dw);
      int r;
      r = 1;
      while ((1 << r) < dw + r + 1) r++;
      return r;
   endfunction

   function automatic bit is_pow2(input int p);
      return (p > 0) && ((p & (p - 1)) == 0);
   endfunction

   // Codeword position of data bit i: i-th index that is neither 0 nor 2^k.
   function automatic int data_pos(input int i);
      int n;
      int res;
      n   = 0;
      res = 0;
      for (int p = 1; p < MAX_CW; p++) begin
         if (!is_pow2(p)) begin
            if (n == i && res == 0) res = p;
            n++;
         end
      end
      return res;
   endfunction

   // Positions whose index has bit k set.
   function automatic cw_mask_t cover_mask(input int k);
      cw_mask_t m;
      m = '0;
      for (int p = 0; p < MAX_CW; p++) begin
         if (((p >> k) & 1) == 1) m[p] = 1'b1;
      end
      return m;
   endfunction

   // Positions that carry data.
   function automatic cw_mask_t data_mask();
      cw_mask_t m;
      m = '0;
      for (int p = 1; p < MAX_CW; p++) begin
         if (!is_pow2(p)) m[p] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/secded_addr_fold.sv
module secded_addr_fold #(
   parameter int ADDR_W = 32,
   parameter int HAM_W  = 7,
   parameter int ENABLE = 1
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [HAM_W-1:0]  fold_o
);

   generate
      if (ENABLE != 0) begin : g_fold
         // Address bit a joins slice (a mod HAM_W); slices are disjoint.
         always_comb begin
            fold_o = '0;
            for (int a = 0; a < ADDR_W; a++) begin
               fold_o[a % HAM_W] = fold_o[a % HAM_W] ^ addr_i[a];
            end
         end
      end else begin : g_nofold
         logic unused_addr;
         assign unused_addr = ^addr_i;
         assign fold_o      = '0;
      end
   endgenerate

endmodule

// File: rtl/secded_encoder.sv
module secded_encoder
   import secded_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int HAM_W  = 7,
   parameter int CW_W   = 72
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [HAM_W-1:0]  fold_i,
   output logic [CW_W-1:0]   code_o
);

   logic [CW_W-1:0]  placed;   // data scattered, check slots zero
   logic [HAM_W-1:0] chk;
   logic [CW_W-1:1]  body;     // everything except the overall bit

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_place
         localparam int P = data_pos(i);
         assign placed[P] = data_i[i];
      end
      for (genvar p = 0; p < CW_W; p++) begin : g_zero
         if (p == 0 || is_pow2(p)) begin : g_slot
            assign placed[p] = 1'b0;
         end
      end

      for (genvar k = 0; k < HAM_W; k++) begin : g_chk
         localparam cw_mask_t MK = cover_mask(k);
         // Odd parity over the group, then address slice folded in.
         assign chk[k] = ~(^(placed & MK[CW_W-1:0])) ^ fold_i[k];
      end

      for (genvar p = 1; p < CW_W; p++) begin : g_body
         if (is_pow2(p)) begin : g_c
            assign body[p] = chk[$clog2(p)];
         end else begin : g_d
            assign body[p] = placed[p];
         end
      end
   endgenerate

   assign code_o = {body, ~(^body)};

endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome
   import secded_pkg::*;
#(
   parameter int HAM_W = 7,
   parameter int CW_W  = 72
) (
   input  logic [CW_W-1:0]  code_i,
   input  logic [HAM_W-1:0] fold_i,
   output logic [HAM_W-1:0] syn_o,
   output logic             pa_fail_o
);

   generate
      for (genvar k = 0; k < HAM_W; k++) begin : g_syn
         localparam cw_mask_t MK = cover_mask(k);
         // A group with an even count of ones (after unfolding) has failed.
         assign syn_o[k] = ~(^(code_i & MK[CW_W-1:0])) ^ fold_i[k];
      end
   endgenerate

   assign pa_fail_o = ~(^code_i);

endmodule

// File: rtl/secded_correct.sv
module secded_correct
   import secded_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int HAM_W  = 7,
   parameter int CW_W   = 72
) (
   input  logic [CW_W-1:0]   code_i,
   input  logic [HAM_W-1:0]  syn_i,
   input  logic              pa_fail_i,
   output logic [DATA_W-1:0] data_o,
   output dec_status_e       status_o
);

   localparam logic [CW_W-1:0] ONE = CW_W'(1);
   localparam cw_mask_t        DM  = data_mask();

   logic [CW_W-1:0] fixed;
   logic            unused_chk;

   always_comb begin
      fixed    = code_i;
      status_o = DEC_UE;
      if (!pa_fail_i && syn_i == '0) begin
         status_o = DEC_OK;
      end else if (pa_fail_i && syn_i == '0) begin
         status_o = DEC_CE;                      // overall bit itself
      end else if (pa_fail_i && int'(syn_i) < CW_W) begin
         status_o = DEC_CE;
         fixed    = code_i ^ (ONE << syn_i);
      end
   end

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_extract
         localparam int P = data_pos(i);
         assign data_o[i] = fixed[P];
      end
   endgenerate

   assign unused_chk = ^(fixed & ~DM[CW_W-1:0]);

endmodule

// File: rtl/secded_codec.sv
module secded_codec
   import secded_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter int ADDR_W    = 32,
   parameter int ADDR_FOLD = 1,
   localparam int HAM_W    = ham_bits(DATA_W),
   localparam int CW_W     = DATA_W + HAM_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] enc_data,
   input  logic [ADDR_W-1:0] enc_addr,
   output logic [CW_W-1:0]   enc_code,
   input  logic [CW_W-1:0]   dec_code,
   input  logic [ADDR_W-1:0] dec_addr,
   output logic [DATA_W-1:0] dec_data,
   output logic [HAM_W-1:0]  dec_syndrome,
   output logic              dec_ok,
   output logic              dec_ce,
   output logic              dec_ue
);

   generate
      if (DATA_W < 4) begin : g_bad_data
         $error("secded_codec: DATA_W must be at least 4");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("secded_codec: ADDR_W must be at least 1");
      end
      if (CW_W > MAX_CW) begin : g_bad_cw
         $error("secded_codec: codeword wider than MAX_CW");
      end
      if (ADDR_FOLD != 0 && ADDR_FOLD != 1) begin : g_bad_fold
         $error("secded_codec: ADDR_FOLD must be 0 or 1");
      end
   endgenerate

   logic [HAM_W-1:0]  enc_fold, dec_fold;
   logic [HAM_W-1:0]  syn;
   logic              pa_fail;
   logic [DATA_W-1:0] fix_data;
   dec_status_e       status;

   secded_addr_fold #(.ADDR_W(ADDR_W), .HAM_W(HAM_W), .ENABLE(ADDR_FOLD)) u_fold_enc (
      .addr_i (enc_addr),
      .fold_o (enc_fold)
   );

   secded_addr_fold #(.ADDR_W(ADDR_W), .HAM_W(HAM_W), .ENABLE(ADDR_FOLD)) u_fold_dec (
      .addr_i (dec_addr),
      .fold_o (dec_fold)
   );

   secded_encoder #(.DATA_W(DATA_W), .HAM_W(HAM_W), .CW_W(CW_W)) u_enc (
      .data_i (enc_data),
      .fold_i (enc_fold),
      .code_o (enc_code)
   );

   secded_syndrome #(.HAM_W(HAM_W), .CW_W(CW_W)) u_syn (
      .code_i    (dec_code),
      .fold_i    (dec_fold),
      .syn_o     (syn),
      .pa_fail_o (pa_fail)
   );

   secded_correct #(.DATA_W(DATA_W), .HAM_W(HAM_W), .CW_W(CW_W)) u_fix (
      .code_i    (dec_code),
      .syn_i     (syn),
      .pa_fail_i (pa_fail),
      .data_o    (fix_data),
      .status_o  (status)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         dec_data     <= '0;
         dec_syndrome <= '0;
         dec_ok       <= 1'b0;
         dec_ce       <= 1'b0;
         dec_ue       <= 1'b0;
      end else begin
         dec_data     <= fix_data;
         dec_syndrome <= syn;
         dec_ok       <= (status == DEC_OK);
         dec_ce       <= (status == DEC_CE);
         dec_ue       <= (status == DEC_UE);
      end
   end

endmodule

// File: rtl/secded_codec_checks.sv
module secded_codec_checks
   import secded_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 32,
   localparam int HAM_W = ham_bits(DATA_W),
   localparam int CW_W  = DATA_W + HAM_W + 1
) (
   input logic              clk,
   input logic              rst,
   input logic [DATA_W-1:0] enc_data,
   input logic [ADDR_W-1:0] enc_addr,
   input logic [CW_W-1:0]   enc_code,
   input logic [CW_W-1:0]   dec_code,
   input logic [ADDR_W-1:0] dec_addr,
   input logic [DATA_W-1:0] dec_data,
   input logic [HAM_W-1:0]  dec_syndrome,
   input logic              dec_ok,
   input logic              dec_ce,
   input logic              dec_ue
);

   assert_enc_odd_R2: assert property (@(posedge clk) disable iff (rst)
      (^enc_code) == 1'b1);

   assert_loopback_R3: assert property (@(posedge clk) disable iff (rst)
      (dec_code == enc_code && dec_addr == enc_addr)
      |=> (dec_ok && dec_syndrome == '0 && dec_data == $past(enc_data)));

   assert_ce_in_range_R4: assert property (@(posedge clk) disable iff (rst)
      dec_ce |-> (int'(dec_syndrome) < CW_W));

   assert_ue_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
      dec_ue |-> (dec_syndrome != '0));

   assert_beyond_end_R8: assert property (@(posedge clk) disable iff (rst)
      (int'(dec_syndrome) >= CW_W) |-> dec_ue);

   assert_one_status_R10: assert property (@(posedge clk) disable iff (rst)
      !rst |=> $onehot({dec_ok, dec_ce, dec_ue}));

   assert_reset_clear_R10: assert property (@(posedge clk)
      rst |=> (!dec_ok && !dec_ce && !dec_ue && dec_data == '0 && dec_syndrome == '0));

endmodule

bind secded_codec secded_codec_checks #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_checks (
   .clk          (clk),
   .rst          (rst),
   .enc_data     (enc_data),
   .enc_addr     (enc_addr),
   .enc_code     (enc_code),
   .dec_code     (dec_code),
   .dec_addr     (dec_addr),
   .dec_data     (dec_data),
   .dec_syndrome (dec_syndrome),
   .dec_ok       (dec_ok),
   .dec_ce       (dec_ce),
   .dec_ue       (dec_ue)
);

// File: tb/secded_codec_test.sv
`timescale 1ns/1ps
module secded_codec_test;

   localparam int DW = 64;
   localparam int AW = 32;
   localparam int HW = 7;
   localparam int CW = 72;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [DW-1:0] enc_data = '0;
   logic [AW-1:0] enc_addr = '0;
   logic [CW-1:0] enc_code;
   logic [CW-1:0] dec_code = '0;
   logic [AW-1:0] dec_addr = '0;
   logic [DW-1:0] dec_data;
   logic [HW-1:0] dec_syndrome;
   logic          dec_ok, dec_ce, dec_ue;

   always #2.5 clk = ~clk;

   secded_codec #(.DATA_W(DW), .ADDR_W(AW), .ADDR_FOLD(1)) uut (
      .clk(clk), .rst(rst),
      .enc_data(enc_data), .enc_addr(enc_addr), .enc_code(enc_code),
      .dec_code(dec_code), .dec_addr(dec_addr),
      .dec_data(dec_data), .dec_syndrome(dec_syndrome),
      .dec_ok(dec_ok), .dec_ce(dec_ce), .dec_ue(dec_ue)
   );

   typedef struct {
      logic [DW-1:0] data;
      logic [HW-1:0] syn;
      logic [2:0]    flags;   // {ok, ce, ue}
      string         req;
   } exp_t;

   exp_t q[$];
   int   n_chk  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;

   task automatic check(input bit good, input string req, input string what,
                        input logic [CW-1:0] act, input logic [CW-1:0] exp);
      n_chk++;
      if (!good) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic bit is_p2(input int p);
      return (p > 0) && ((p & (p - 1)) == 0);
   endfunction

   function automatic logic [HW-1:0] m_fold(input logic [AW-1:0] a);
      logic [HW-1:0] f;
      f = '0;
      for (int i = 0; i < AW; i++) f[i % HW] ^= a[i];
      return f;
   endfunction

   function automatic logic [CW-1:0] m_encode(input logic [DW-1:0] d, input logic [AW-1:0] a);
      logic [CW-1:0] c;
      logic [HW-1:0] f;
      int n;
      c = '0;
      n = 0;
      f = m_fold(a);
      for (int p = 1; p < CW; p++) begin
         if (!is_p2(p)) begin
            c[p] = d[n];
            n++;
         end
      end
      for (int k = 0; k < HW; k++) begin
         logic x;
         x = 1'b1;
         for (int p = 1; p < CW; p++) begin
            if (p != (1 << k) && ((p >> k) & 1) == 1) x ^= c[p];
         end
         c[1 << k] = x ^ f[k];
      end
      c[0] = ~(^c[CW-1:1]);
      return c;
   endfunction

   function automatic logic [DW-1:0] m_extract(input logic [CW-1:0] c);
      logic [DW-1:0] d;
      int n;
      n = 0;
      d = '0;
      for (int p = 1; p < CW; p++) begin
         if (!is_p2(p)) begin
            d[n] = c[p];
            n++;
         end
      end
      return d;
   endfunction

   // Driver: encode, check the encoder, corrupt, present to decoder, push expectation.
   task automatic send(input logic [DW-1:0] d, input logic [AW-1:0] ae,
                       input logic [AW-1:0] ad, input logic [CW-1:0] fm, input string req);
      exp_t e;
      logic [CW-1:0] code;
      logic [HW-1:0] s;
      logic          pf;
      @(negedge clk);
      enc_data = d;
      enc_addr = ae;
      #1;
      check(enc_code === m_encode(d, ae), "R1", "enc_code", enc_code, m_encode(d, ae));
      code = enc_code ^ fm;
      dec_code = code;
      dec_addr = ad;
      s = m_fold(ae) ^ m_fold(ad);
      for (int p = 0; p < CW; p++) if (fm[p]) s ^= HW'(p);
      pf = ^fm;
      e.syn = s;
      e.req = req;
      e.data = m_extract(code);
      if (!pf && s == '0) e.flags = 3'b100;
      else if (pf && s == '0) e.flags = 3'b010;
      else if (pf && int'(s) < CW) begin
         e.flags = 3'b010;
         e.data  = m_extract(code ^ (CW'(1) << s));
      end else e.flags = 3'b001;
      q.push_back(e);
   endtask

   // Monitor: one result per cycle, one register after the driven input.
   always @(posedge clk) begin
      #1;
      if (!rst && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check(dec_data === e.data, e.req, "dec_data", CW'(dec_data), CW'(e.data));
         check(dec_syndrome === e.syn, e.req, "dec_syndrome", CW'(dec_syndrome), CW'(e.syn));
         check({dec_ok, dec_ce, dec_ue} === e.flags, e.req, "flags",
               CW'({dec_ok, dec_ce, dec_ue}), CW'(e.flags));
         check($countones({dec_ok, dec_ce, dec_ue}) == 1, "R10", "one flag",
               CW'({dec_ok, dec_ce, dec_ue}), CW'(e.flags));
      end
   end

   task automatic check_groups(input logic [DW-1:0] d, input logic [AW-1:0] a);
      logic [HW-1:0] f;
      @(negedge clk);
      enc_data = d;
      enc_addr = a;
      #1;
      f = m_fold(a);
      for (int k = 0; k < HW; k++) begin
         logic x;
         x = 1'b0;
         for (int p = 1; p < CW; p++) if (((p >> k) & 1) == 1) x ^= enc_code[p];
         check((x ^ f[k]) == 1'b1, "R2", "group parity", CW'(x ^ f[k]), CW'(1));
      end
      check((^enc_code) == 1'b1, "R2", "whole parity", CW'(^enc_code), CW'(1));
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #250000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R10 watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

   localparam logic [DW-1:0] PAT = 64'hA5C3_0F1E_9B87_2D64;
   localparam logic [AW-1:0] ADR = 32'h1357_9BDF;

   initial begin
      // R10: reset state
      repeat (3) @(posedge clk);
      #1;
      check({dec_ok, dec_ce, dec_ue} == 3'b000, "R10", "flags in reset",
            CW'({dec_ok, dec_ce, dec_ue}), CW'(0));
      check(dec_data == '0 && dec_syndrome == '0, "R10", "data/syn in reset",
            CW'(dec_data), CW'(0));
      @(negedge clk);
      rst = 1'b0;

      // R1: explicit positions of the end data bits
      @(negedge clk);
      enc_data = 64'h1;
      enc_addr = '0;
      #1;
      check(enc_code[3] == 1'b1, "R1", "data bit 0 at position 3", CW'(enc_code[3]), CW'(1));
      enc_data = 64'h8000_0000_0000_0000;
      #1;
      check(enc_code[71] == 1'b1, "R1", "data bit 63 at position 71", CW'(enc_code[71]), CW'(1));

      // R2: group parity for several patterns
      check_groups('0, '0);
      check_groups('1, ADR);
      check_groups(PAT, 32'hFFFF_FFFF);

      // R3: clean words
      send('0, '0, '0, '0, "R3");
      send('1, '0, '0, '0, "R3");
      send(64'h0123_4567_89AB_CDEF, ADR, ADR, '0, "R3");
      send(64'h5555_5555_AAAA_AAAA, 32'hDEAD_BEEF, 32'hDEAD_BEEF, '0, "R3");

      // R4, R5, R6: every single-bit inversion
      for (int p = 0; p < CW; p++) begin
         string r;
         r = (p == 0) ? "R6" : (is_p2(p) ? "R5" : "R4");
         send(PAT, ADR, ADR, CW'(1) << p, r);
      end

      // R7: double inversions
      send(PAT, ADR, ADR, (CW'(1) << 3) | (CW'(1) << 5), "R7");
      send(PAT, ADR, ADR, (CW'(1) << 0) | (CW'(1) << 9), "R7");
      send(~PAT, '0, '0, (CW'(1) << 64) | (CW'(1) << 70), "R7");
      send(PAT, ADR, ADR, (CW'(1) << 1) | (CW'(1) << 2), "R7");

      // R8: overall parity fails, syndrome beyond 71
      send(PAT, ADR, ADR, (CW'(1) << 0) | (CW'(1) << 11) | (CW'(1) << 67), "R8");
      send(PAT, ADR, ADR, (CW'(1) << 0) | (CW'(1) << 56) | (CW'(1) << 71), "R8");

      // R9: address folding
      send(PAT, 32'h0, 32'h1, '0, "R9");
      send(PAT, 32'h0, 32'h0000_0040, '0, "R9");
      send(PAT, 32'h0, 32'h0000_0081, '0, "R9");   // bits 0 and 7 share a slice
      send(PAT, ADR, ADR ^ 32'h0000_0003, '0, "R9");
      send(PAT, ADR, ADR ^ 32'h1, CW'(1) << 20, "R9");

      repeat (3) @(negedge clk);
      done = 1'b1;
      finish_run();
   end

endmodule